// File: doc/BRIEF.md
# Removable Card Presence Monitor

This block watches the mechanical card-detect contact of a removable memory card socket and turns it into a clean presence flag. The raw contact level is first brought into the clock domain through a two-stage synchroniser. A debounce counter then requires the level to hold unchanged for a programmable number of cycles before the flag reports a card. Whenever the synchronised level moves, the flag drops to 0 and the count starts again.

Changes of the presence flag raise two sticky interrupt status bits, one for a new card and one for a card that has gone. Software clears each bit by writing 1 to it. The block also holds the bus power bit and the card clock enable bit. If a card disappears while both bits are on, the block turns both off by itself. A software full reset clears the status bits and the power and clock bits. It does not touch the presence flag or the debounce state. Only the synchronous hardware reset does that.

Top module: `sd_card_presence`

## Requirements
- R1: After the hardware reset (`rst_n` low at a clock edge), all five outputs are 0.
- R2: `det_raw_i` = 1 means a card is seated. `present_o` becomes 1 only after the synchronised level has held 1 for `DEB_CYCLES` consecutive cycles. The flag rises no later than `DEB_CYCLES`+4 clock edges after the last change of the raw input.
- R3: Any change of the synchronised detect level restarts the debounce count, and `present_o` reads 0 during the count. A bouncing insertion therefore gives 0 for at least `DEB_CYCLES` edges after its last bounce.
- R4: A 0-to-1 transition of `present_o` sets `irq_ins_o`.
- R5: A 1-to-0 transition of `present_o` sets `irq_rem_o`.
- R6: Both status bits are sticky until a clear strobe (`clr_ins_i`, `clr_rem_i`, write-1-to-clear) arrives. If a new event and its clear fall in the same cycle, the event wins and the bit stays 1.
- R7: `sw_rst_i` clears both status bits, `bus_pwr_o` and `clk_en_o`. It leaves `present_o` and the debounce state unchanged and creates no insertion or removal event.
- R8: On a removal event, the block clears both `bus_pwr_o` and `clk_en_o` if both were 1. If only one of them was 1, it clears neither.
- R9: Detection and the insertion event work with `bus_pwr_o` at 0.
- R10: `bus_pwr_o` and `clk_en_o` load `pwr_wd_i` and `clk_wd_i` on cycles where `pwr_we_i` and `clk_we_i` are high, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| det_raw_i | input | 1 | Raw socket detect level, 1 = card seated, asynchronous |
| sw_rst_i | input | 1 | Software full-reset request, one cycle |
| clr_ins_i | input | 1 | Write-1 clear of the insertion status bit |
| clr_rem_i | input | 1 | Write-1 clear of the removal status bit |
| pwr_we_i | input | 1 | Write strobe for the bus power bit |
| pwr_wd_i | input | 1 | Value written to the bus power bit |
| clk_we_i | input | 1 | Write strobe for the card clock enable bit |
| clk_wd_i | input | 1 | Value written to the card clock enable bit |
| present_o | output | 1 | Debounced card presence |
| irq_ins_o | output | 1 | Sticky insertion status |
| irq_rem_o | output | 1 | Sticky removal status |
| bus_pwr_o | output | 1 | Bus power bit |
| clk_en_o | output | 1 | Card clock enable bit |

## Verification
The bench drives a bouncing insertion and checks that presence stays 0 through the bounces and for the full count after the last one. A design that fails to restart the count would report a card too early. It issues a software full reset while a card is present. A design that reset the edge-detect history there would raise a spurious insertion or lose presence. It lines a clear strobe up with the exact cycle of an insertion event, and a design that let the clear win would lose that event. It also removes the card once with both power and clock on and once with only power on. This catches a guard that misses the forced shutdown or applies it too broadly.

// File: rtl/cd_pkg.sv
// Shared types for the card presence monitor.
package cd_pkg;
    // Single-cycle presence transition events.
    typedef struct packed {
        logic ins;  // presence went 0 -> 1
        logic rem;  // presence went 1 -> 0
    } cd_evt_t;
endpackage

// File: rtl/cd_sync2.sv
// Two-stage synchroniser for the asynchronous detect contact.
// Assumes the input is a slow level; no pulse capture is intended.
module cd_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic s1_q, s2_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/cd_debounce.sv
// Debounces the synchronised detect level into a presence flag.
// The flag drops to 0 on any level change. It is set once the level has
// held 1 for DEB_CYCLES cycles. Only the hardware reset clears this state.
module cd_debounce #(
    parameter int DEB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic present_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEB_CYCLES - 1);

    logic          last_q;
    logic [CW-1:0] cnt_q;
    logic          pres_q;

    // Restart on change, count while stable, publish when the count completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            cnt_q  <= '0;
            pres_q <= 1'b0;
        end else if (lvl_i != last_q) begin
            last_q <= lvl_i;
            cnt_q  <= '0;
            pres_q <= 1'b0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pres_q <= last_q;
        end
    end

    assign present_o = pres_q;

    AST_ZERO_WHILE_BOUNCING: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i != last_q) |=> !present_o);  // R3
endmodule

// File: rtl/cd_event_status.sv
// Edge-detects the presence flag and keeps sticky write-1-clear status.
// An event in the same cycle as a clear or software reset wins.
// The edge history is reset by hardware only.
module cd_event_status
    import cd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sw_rst_i,
    input  logic    present_i,
    input  logic    clr_ins_i,
    input  logic    clr_rem_i,
    output cd_evt_t evt_o,
    output logic    irq_ins_o,
    output logic    irq_rem_o
);
    logic pres_d_q;
    logic ins_q, rem_q;

    // Remember last cycle's presence for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pres_d_q <= 1'b0;
        else        pres_d_q <= present_i;
    end

    assign evt_o.ins = present_i & ~pres_d_q;
    assign evt_o.rem = ~present_i & pres_d_q;

    // Sticky status bits: set wins over clear and software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_q <= 1'b0;
            rem_q <= 1'b0;
        end else begin
            if (evt_o.ins)                  ins_q <= 1'b1;
            else if (clr_ins_i || sw_rst_i) ins_q <= 1'b0;
            if (evt_o.rem)                  rem_q <= 1'b1;
            else if (clr_rem_i || sw_rst_i) rem_q <= 1'b0;
        end
    end

    assign irq_ins_o = ins_q;
    assign irq_rem_o = rem_q;

    AST_INS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (present_i && !pres_d_q) |=> irq_ins_o);  // R4
    AST_REM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!present_i && pres_d_q) |=> irq_rem_o);  // R5
    AST_STICKY_INS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ins_o && !clr_ins_i && !sw_rst_i) |=> irq_ins_o);  // R6
endmodule

// File: rtl/cd_power_guard.sv
// Holds the bus power and card clock enable bits.
// A removal while both are on forces both off, ahead of any write.
module cd_power_guard
    import cd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sw_rst_i,
    input  cd_evt_t evt_i,
    input  logic    pwr_we_i,
    input  logic    pwr_wd_i,
    input  logic    clk_we_i,
    input  logic    clk_wd_i,
    output logic    bus_pwr_o,
    output logic    clk_en_o
);
    logic pwr_q, cen_q;
    logic force_off;

    assign force_off = evt_i.rem & pwr_q & cen_q;

    // Priority: forced shutdown, then software reset, then writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b0;
            cen_q <= 1'b0;
        end else if (force_off || sw_rst_i) begin
            pwr_q <= 1'b0;
            cen_q <= 1'b0;
        end else begin
            if (pwr_we_i) pwr_q <= pwr_wd_i;
            if (clk_we_i) cen_q <= clk_wd_i;
        end
    end

    assign bus_pwr_o = pwr_q;
    assign clk_en_o  = cen_q;

    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.rem && bus_pwr_o && clk_en_o) |=> (!bus_pwr_o && !clk_en_o));  // R8
endmodule

// File: rtl/sd_card_presence.sv
// Top of the removable card presence monitor: synchroniser, debounce,
// event status and power guard. Assumes det_raw_i is asynchronous and
// all other inputs are synchronous to clk.
module sd_card_presence
    import cd_pkg::*;
#(
    parameter int DEB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_raw_i,
    input  logic sw_rst_i,
    input  logic clr_ins_i,
    input  logic clr_rem_i,
    input  logic pwr_we_i,
    input  logic pwr_wd_i,
    input  logic clk_we_i,
    input  logic clk_wd_i,
    output logic present_o,
    output logic irq_ins_o,
    output logic irq_rem_o,
    output logic bus_pwr_o,
    output logic clk_en_o
);
    logic    det_sync;
    logic    present;
    cd_evt_t evt;

    cd_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (det_raw_i),
        .q_o   (det_sync)
    );

    cd_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (det_sync),
        .present_o (present)
    );

    cd_event_status u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst_i  (sw_rst_i),
        .present_i (present),
        .clr_ins_i (clr_ins_i),
        .clr_rem_i (clr_rem_i),
        .evt_o     (evt),
        .irq_ins_o (irq_ins_o),
        .irq_rem_o (irq_rem_o)
    );

    cd_power_guard u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst_i  (sw_rst_i),
        .evt_i     (evt),
        .pwr_we_i  (pwr_we_i),
        .pwr_wd_i  (pwr_wd_i),
        .clk_we_i  (clk_we_i),
        .clk_wd_i  (clk_wd_i),
        .bus_pwr_o (bus_pwr_o),
        .clk_en_o  (clk_en_o)
    );

    assign present_o = present;

    AST_SWRST_KEEPS_PRESENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst_i && present && $stable(det_sync)) |=> present_o);  // R7
endmodule

// File: tb/sd_card_presence_tb.sv
// Scoreboard bench: the driver pushes expected output vectors, and the
// monitor pops and compares them at the next falling edge.
module sd_card_presence_tb;
    localparam int DEB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_raw = 1'b0, sw_rst = 1'b0, clr_ins = 1'b0, clr_rem = 1'b0;
    logic pwr_we = 1'b0, pwr_wd = 1'b0, clk_we = 1'b0, clk_wd = 1'b0;
    logic present, irq_ins, irq_rem, bus_pwr, clk_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Vector order: {present, irq_ins, irq_rem, bus_pwr, clk_en}
    int       q_req[$];
    logic [4:0] q_mask[$];
    logic [4:0] q_exp[$];

    always #10 clk = ~clk;  // 50 MHz

    sd_card_presence #(.DEB_CYCLES(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .det_raw_i(det_raw), .sw_rst_i(sw_rst),
        .clr_ins_i(clr_ins), .clr_rem_i(clr_rem),
        .pwr_we_i(pwr_we), .pwr_wd_i(pwr_wd), .clk_we_i(clk_we), .clk_wd_i(clk_wd),
        .present_o(present), .irq_ins_o(irq_ins), .irq_rem_o(irq_rem),
        .bus_pwr_o(bus_pwr), .clk_en_o(clk_en)
    );

    task automatic expect_out(input int req, input logic [4:0] mask, input logic [4:0] exp);
        q_req.push_back(req);
        q_mask.push_back(mask);
        q_exp.push_back(exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (q_req.size() > 0) begin
            automatic int r = q_req.pop_front();
            automatic logic [4:0] m = q_mask.pop_front();
            automatic logic [4:0] e = q_exp.pop_front();
            automatic logic [4:0] a = {present, irq_ins, irq_rem, bus_pwr, clk_en};
            checks++;
            if ((a & m) !== (e & m)) begin
                errors++;
                $display("FAIL R%0d: actual %b expected %b (mask %b)", r, a & m, e & m, m);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_out(1, 5'b11111, 5'b00000);  // R1 reset state
        step(1);

        // Bouncing insertion with power off: R3, R2, R9, R4
        det_raw = 1'b1; step(5);
        det_raw = 1'b0; step(3);
        det_raw = 1'b1; step(DEB);
        expect_out(3, 5'b11000, 5'b00000);  // R3 still 0 after bounces
        step(6);
        expect_out(2, 5'b10000, 5'b10000);  // R2 presence after stable count
        expect_out(9, 5'b10011, 5'b10000);  // R9 detect with power off
        expect_out(4, 5'b01000, 5'b01000);  // R4 insertion status
        step(20);
        expect_out(6, 5'b01000, 5'b01000);  // R6 sticky
        clr_ins = 1'b1; step(1); clr_ins = 1'b0;
        expect_out(6, 5'b01000, 5'b00000);  // R6 write-1 clear

        // Power and clock writes: R10
        pwr_we = 1'b1; pwr_wd = 1'b1; clk_we = 1'b1; clk_wd = 1'b1; step(1);
        pwr_we = 1'b0; clk_we = 1'b0;
        expect_out(10, 5'b00011, 5'b00011);

        // Software full reset: R7
        sw_rst = 1'b1; step(1); sw_rst = 1'b0;
        expect_out(7, 5'b11111, 5'b10000);
        step(4);
        expect_out(7, 5'b11111, 5'b10000);  // no spurious insertion

        // Removal with power and clock on: R5, R8
        pwr_we = 1'b1; clk_we = 1'b1; step(1);
        pwr_we = 1'b0; clk_we = 1'b0;
        expect_out(10, 5'b00011, 5'b00011);
        det_raw = 1'b0; step(6);
        expect_out(5, 5'b10100, 5'b00100);  // R5 removal status
        expect_out(8, 5'b00011, 5'b00000);  // R8 forced off
        clr_rem = 1'b1; step(1); clr_rem = 1'b0;
        expect_out(6, 5'b00100, 5'b00000);  // R6 clear removal

        // Clean insertion with the clear landing on the event cycle: R6
        det_raw = 1'b1; step(DEB + 3);
        expect_out(6, 5'b11000, 5'b10000);  // alignment: presence just rose
        clr_ins = 1'b1; step(1); clr_ins = 1'b0;
        expect_out(6, 5'b01000, 5'b01000);  // R6 event wins over clear
        clr_ins = 1'b1; step(1); clr_ins = 1'b0;

        // Removal with only power on: R8 leaves power alone
        pwr_we = 1'b1; pwr_wd = 1'b1; clk_we = 1'b1; clk_wd = 1'b0; step(1);
        pwr_we = 1'b0; clk_we = 1'b0;
        det_raw = 1'b0; step(6);
        expect_out(8, 5'b10111, 5'b00110);

        // Hardware reset again: R1
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        expect_out(1, 5'b11111, 5'b00000);
        step(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule